// File: doc/BRIEF.md
# UART Receive Holding Queue

This block sits between a UART receive deserializer and the register file of the serial port. It keeps up to four received bytes in arrival order, raises a receiver-ready flag while anything is held, and raises a queue-full flag when all four slots are taken. Software, through the control and status block, removes the oldest byte by reading the receive buffer. The control block drives the receiver enable and a one-cycle receiver reset into this block, and it reads the two flags back. The queue-full flag can be selected there as the receive interrupt source instead of receiver ready.

Bytes come in on a valid/ready stream. A byte moves on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while the receiver is disabled, while the queue is full, during a receiver reset, and in a cycle that carries a break event. In those cycles a waiting byte is not taken, and the source holds it or drops it. A line break comes in on a separate pulse. It always sets a sticky break-change interrupt flag and stores a zero byte marked as a break. If the queue is already full and no read happens in the same cycle, that zero overwrites the newest stored byte. The receive-buffer read is a plain strobe. `rd_data` always shows the oldest byte (zero when the queue is empty), and the queue advances at the clock edge that ends a cycle in which `rd_req` is high.

Top module: `rx_hold_queue`

## Requirements
- R1: The queue never holds more than 4 bytes, and `in_ready` is low whenever `full_flag` is high.
- R2: After a byte is stored, `rdy_flag` is high from the next cycle on. The store that brings the count to 4 makes `full_flag` high in the next cycle.
- R3: A byte is stored only in a cycle where `in_valid`, `rx_en` and `in_ready` are all high. With `rx_en` low, `in_ready` is low and the flags do not change.
- R4: A `brk_evt` pulse sets `brk_irq` in the next cycle and stores a zero byte. `brk_clr` clears `brk_irq`. If both are high in the same cycle, the set wins.
- R5: A break that arrives while the queue is full, with no read in the same cycle, replaces the newest byte with zero. The queue stays full, and the three older bytes are kept in order.
- R6: `rd_data` shows the oldest stored byte. A cycle with `rd_req` high removes that byte and moves the rest forward, which clears `full_flag`. `rdy_flag` drops once the last byte is removed.
- R7: A `rx_flush` pulse empties the queue and clears `rdy_flag`, `full_flag` and `rcvd_brk` in the next cycle. It takes priority over a store or a read in the same cycle.
- R8: With the queue empty, `rd_data` is zero and `rd_req` has no effect. A byte stored afterwards is the next one read.
- R9: A store and a read in the same cycle keep the count unchanged. The new byte lands behind the bytes already held.
- R10: `rcvd_brk` is high while a break byte is held in the queue. It drops in the cycle after that byte is read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable from the control block |
| rx_flush | input | 1 | One-cycle receiver reset command |
| in_valid | input | 1 | Received byte present on `in_data` |
| in_ready | output | 1 | Queue will take the byte this cycle |
| in_data | input | 8 | Received byte |
| brk_evt | input | 1 | One-cycle line-break event |
| brk_clr | input | 1 | Clears the break-change interrupt flag |
| rd_req | input | 1 | Receive-buffer read strobe |
| rd_data | output | 8 | Oldest stored byte, zero when empty |
| rdy_flag | output | 1 | Receiver ready: at least one byte held |
| full_flag | output | 1 | All four slots occupied |
| brk_irq | output | 1 | Sticky break-change interrupt flag |
| rcvd_brk | output | 1 | A break byte is somewhere in the queue |

## Verification
A wrong count or a slot that shifts wrongly shows up at `rd_data` on a later read. Bytes come out in the wrong order, a byte is repeated, or a stale byte appears where zero is expected. This can show as late as four reads after the faulty cycle, so the directed cases drain the queue completely every time. A count that is off by one shows at once as a `full_flag` or `rdy_flag` edge one cycle early or late, and as a wrong `in_ready`. A break tag left behind in a vacated slot shows as `rcvd_brk` staying high after the break byte has been read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Kind of write performed on the storage in a given cycle
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_APPEND  = 2'd1,  // place behind the current tail (after any pop)
    WR_REPLACE = 2'd2   // overwrite the newest slot of a full queue
  } wr_kind_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          pop,
  input  wr_kind_t      wr_kind,
  input  logic [W-1:0]  wr_data,
  input  logic          wr_tag,
  output logic [CW-1:0] cnt,
  output logic [W-1:0]  head_data,
  output logic          any_tag
);
  logic [W-1:0]     dat_q [DEPTH];
  logic [DEPTH-1:0] tag_q;
  logic [CW-1:0]    cnt_q;
  logic             pop_ok;
  logic [CW-1:0]    cnt_pop;
  logic [CW-1:0]    wr_idx;

  assign pop_ok  = pop && (cnt_q != '0);
  assign cnt_pop = cnt_q - CW'(pop_ok);
  assign wr_idx  = (wr_kind == WR_REPLACE) ? CW'(DEPTH - 1) : cnt_pop;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] sh_d;
    logic         sh_t;
    logic         hit;
    if (i == DEPTH - 1) begin : g_last
      assign sh_d = pop_ok ? '0 : dat_q[i];
      assign sh_t = pop_ok ? 1'b0 : tag_q[i];
    end else begin : g_mid
      assign sh_d = pop_ok ? dat_q[i+1] : dat_q[i];
      assign sh_t = pop_ok ? tag_q[i+1] : tag_q[i];
    end
    assign hit = (wr_kind != WR_NONE) && (wr_idx == CW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q[i] <= '0;
        tag_q[i] <= 1'b0;
      end else if (flush) begin
        dat_q[i] <= '0;
        tag_q[i] <= 1'b0;
      end else if (hit) begin
        dat_q[i] <= wr_data;
        tag_q[i] <= wr_tag;
      end else begin
        dat_q[i] <= sh_d;
        tag_q[i] <= sh_t;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (flush)     cnt_q <= '0;
    else                cnt_q <= cnt_pop + CW'(wr_kind == WR_APPEND);
  end

  assign cnt       = cnt_q;
  assign head_data = dat_q[0];
  assign any_tag   = |tag_q;

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r8_empty_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (head_data == '0 && !any_tag));

  a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q != '0 && !flush && wr_kind == WR_NONE) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && !any_tag));
endmodule

// File: rtl/rxq_brk_irq.sv
module rxq_brk_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);

  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue
  import rxq_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         rx_flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         brk_evt,
  input  logic         brk_clr,
  input  logic         rd_req,
  output logic [W-1:0] rd_data,
  output logic         rdy_flag,
  output logic         full_flag,
  output logic         brk_irq,
  output logic         rcvd_brk
);
  logic [CW-1:0] cnt;
  logic [W-1:0]  head;
  logic          any_tag;
  logic          accept;
  logic          pop_live;
  wr_kind_t      wr_kind;
  logic [W-1:0]  wr_data;

  assign full_flag = (cnt == CW'(DEPTH));
  assign rdy_flag  = (cnt != '0);
  assign in_ready  = rx_en && !full_flag && !rx_flush && !brk_evt;
  assign accept    = in_valid && in_ready;
  assign pop_live  = rd_req && rdy_flag;

  always_comb begin
    wr_kind = WR_NONE;
    if (rx_flush)        wr_kind = WR_NONE;
    else if (brk_evt)    wr_kind = (full_flag && !pop_live) ? WR_REPLACE : WR_APPEND;
    else if (accept)     wr_kind = WR_APPEND;
  end

  assign wr_data = brk_evt ? '0 : in_data;

  rxq_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .pop       (rd_req),
    .wr_kind   (wr_kind),
    .wr_data   (wr_data),
    .wr_tag    (brk_evt),
    .cnt       (cnt),
    .head_data (head),
    .any_tag   (any_tag)
  );

  rxq_brk_irq u_brk (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (brk_evt),
    .clr   (brk_clr),
    .flag  (brk_irq)
  );

  assign rd_data  = head;
  assign rcvd_brk = any_tag;

  a_r3_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag |-> !in_ready);

  a_r2_fill_raises_full: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !rd_req && cnt == CW'(DEPTH - 1)) |=> full_flag);

  a_r9_pushpop_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pop_live) |=> (cnt == $past(cnt)));

  a_r5_replace_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_evt && full_flag && !rd_req && !rx_flush) |=> (full_flag && rcvd_brk));
endmodule

// File: tb/rx_hold_queue_bench.sv
module rx_hold_queue_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, rx_flush = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       brk_evt = 1'b0, brk_clr = 1'b0, rd_req = 1'b0;
  logic       in_ready, rdy_flag, full_flag, brk_irq, rcvd_brk;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_hold_queue u_rx_hold_queue (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_flush(rx_flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .brk_evt(brk_evt), .brk_clr(brk_clr), .rd_req(rd_req), .rd_data(rd_data),
    .rdy_flag(rdy_flag), .full_flag(full_flag), .brk_irq(brk_irq), .rcvd_brk(rcvd_brk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // store one byte over one cycle; called at a negedge
  task automatic put(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // read one byte; the head is checked before the edge that pops it
  task automatic take(input string req, input logic [7:0] exp);
    rd_req = 1'b1;
    #1 chk(req, rd_data, exp);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R6 reset rdy", rdy_flag, 0);
    chk("R2 reset full", full_flag, 0);
    chk("R4 reset brk_irq", brk_irq, 0);
    chk("R10 reset rcvd_brk", rcvd_brk, 0);
    chk("R8 reset rd_data", rd_data, 0);
  endtask

  task automatic t_disabled;
    rx_en = 1'b0; in_valid = 1'b1; in_data = 8'h5A;
    #1 chk("R3 in_ready low when disabled", in_ready, 0);
    @(negedge clk); in_valid = 1'b0;
    chk("R3 disabled byte not stored", rdy_flag, 0);
    rx_en = 1'b1;
    #1 chk("R3 in_ready high when enabled", in_ready, 1);
  endtask

  task automatic t_fill_drain;
    put(8'hA1);
    chk("R2 rdy after first byte", rdy_flag, 1);
    chk("R2 not full at one", full_flag, 0);
    put(8'hA2); put(8'hA3);
    chk("R2 not full at three", full_flag, 0);
    put(8'hA4);
    chk("R2 full at four", full_flag, 1);
    in_valid = 1'b1; in_data = 8'hEE;
    #1 chk("R1 in_ready low when full", in_ready, 0);
    @(negedge clk); in_valid = 1'b0;
    take("R6 oldest first", 8'hA1);
    chk("R6 full clears on read", full_flag, 0);
    take("R6 order 2", 8'hA2);
    take("R6 order 3", 8'hA3);
    chk("R6 rdy still set", rdy_flag, 1);
    take("R1 fifth byte dropped", 8'hA4);
    chk("R6 rdy clears when empty", rdy_flag, 0);
  endtask

  task automatic t_empty_read;
    rd_req = 1'b1;
    #1 chk("R8 empty read is zero", rd_data, 0);
    @(negedge clk); rd_req = 1'b0;
    chk("R8 empty read keeps rdy low", rdy_flag, 0);
    put(8'h3C);
    take("R8 next byte after empty read", 8'h3C);
    chk("R8 empty after single", rdy_flag, 0);
  endtask

  task automatic t_break;
    brk_evt = 1'b1;
    #1 chk("R3 in_ready low on break", in_ready, 0);
    @(negedge clk); brk_evt = 1'b0;
    chk("R4 break sets irq", brk_irq, 1);
    chk("R4 break stores byte", rdy_flag, 1);
    chk("R10 rcvd_brk set", rcvd_brk, 1);
    brk_clr = 1'b1; @(negedge clk); brk_clr = 1'b0;
    chk("R4 clear drops irq", brk_irq, 0);
    brk_evt = 1'b1; brk_clr = 1'b1; @(negedge clk); brk_evt = 1'b0; brk_clr = 1'b0;
    chk("R4 set wins over clear", brk_irq, 1);
    take("R4 break byte is zero", 8'h00);
    chk("R10 rcvd_brk held for second break", rcvd_brk, 1);
    take("R4 second break byte zero", 8'h00);
    chk("R10 rcvd_brk clears after pop", rcvd_brk, 0);
    brk_clr = 1'b1; @(negedge clk); brk_clr = 1'b0;
  endtask

  task automatic t_break_full;
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    chk("R10 no break held yet", rcvd_brk, 0);
    brk_evt = 1'b1; @(negedge clk); brk_evt = 1'b0;
    chk("R5 still full after replace", full_flag, 1);
    chk("R5 rcvd_brk after replace", rcvd_brk, 1);
    take("R5 older byte 1 kept", 8'h11);
    take("R5 older byte 2 kept", 8'h22);
    take("R5 older byte 3 kept", 8'h33);
    chk("R10 break still held", rcvd_brk, 1);
    take("R5 newest replaced by zero", 8'h00);
    chk("R5 empty after drain", rdy_flag, 0);
    chk("R10 rcvd_brk cleared", rcvd_brk, 0);
    brk_clr = 1'b1; @(negedge clk); brk_clr = 1'b0;
  endtask

  task automatic t_pushpop;
    put(8'h01); put(8'h02);
    in_valid = 1'b1; in_data = 8'h03; rd_req = 1'b1;
    #1 chk("R9 head during push+pop", rd_data, 8'h01);
    @(negedge clk); in_valid = 1'b0; rd_req = 1'b0;
    chk("R9 not full after push+pop", full_flag, 0);
    take("R9 order kept 2", 8'h02);
    take("R9 order kept 3", 8'h03);
    chk("R9 count unchanged then drained", rdy_flag, 0);
    put(8'h71); put(8'h72); put(8'h73);
    in_valid = 1'b1; in_data = 8'h74; rd_req = 1'b1;
    @(negedge clk); in_valid = 1'b0; rd_req = 1'b0;
    chk("R9 three stays three", full_flag, 0);
    put(8'h75);
    chk("R9 count was three", full_flag, 1);
    take("R9 seq 72", 8'h72); take("R9 seq 73", 8'h73);
    take("R9 seq 74", 8'h74); take("R9 seq 75", 8'h75);
  endtask

  task automatic t_flush;
    put(8'hC1); put(8'hC2);
    brk_evt = 1'b1; @(negedge clk); brk_evt = 1'b0;
    rx_flush = 1'b1; in_valid = 1'b1; in_data = 8'hC3; rd_req = 1'b1;
    #1 chk("R7 in_ready low during flush", in_ready, 0);
    @(negedge clk); rx_flush = 1'b0; in_valid = 1'b0; rd_req = 1'b0;
    chk("R7 rdy cleared", rdy_flag, 0);
    chk("R7 full cleared", full_flag, 0);
    chk("R7 rcvd_brk cleared", rcvd_brk, 0);
    chk("R7 rd_data zero", rd_data, 0);
    put(8'hD0);
    take("R7 fresh after flush", 8'hD0);
    brk_clr = 1'b1; @(negedge clk); brk_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_fill_drain();
    t_empty_read();
    t_break();
    t_break_full();
    t_pushpop();
    t_flush();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule